// File: doc/BRIEF.md
# Quantized Linear-Model Gradient Engine

This block trains a dense linear model by stochastic gradient descent on samples whose features arrive as low-precision integers. Each 512-bit input line carries a group of features of one sample. Every feature appears twice in the line, as two independent quantizations. The first copy is multiplied against the fixed-point model and summed by a pipelined adder tree. The label is subtracted from the finished dot product, and the difference is scaled by an arithmetic right shift that stands for the step size. The result is then multiplied by the second copy to form one gradient term per feature. These terms accumulate in on-chip storage. When the configured number of samples has been seen, the accumulated gradient is subtracted from the model and cleared.

The feature width `QBITS` is fixed at build time to 8, 4, 2 or 1 bits. With 8, 4 or 2 bits, a whole line feeds the lanes in one cycle. With 1 bit, a line holds 256 features, so it is consumed as two halves of 128 on consecutive cycles and the line rate halves. With 1 bit the multipliers reduce to multiplexers. The default build is the 1-bit variant with 512 features (two lines per sample), a batch of 2 samples and a shift of 2.

Top module: `qsgd_engine`

## Requirements
- R1: After reset every model word reads 0, `inReady` is 1 and `errValid` is 0.
- R2: In a line, feature j occupies bits [2·QBITS·j +: 2·QBITS]. The low QBITS bits are the dot copy and the high QBITS bits are the gradient copy. The feature's model index is line·(LINE_BITS/(2·QBITS)) + j. With 1-bit data a field value is 0 or 1; wider fields are signed two's complement.
- R3: Once per sample, `errValid` pulses for one cycle with `errOut` = (Σ model[f]·dot[f] − label) >>> STEP_SHIFT, in 32-bit wrapping signed arithmetic. The label is the `inLabel` value on the sample's first line.
- R4: After the BATCH-th sample of a batch, model[f] has decreased by the sum over that batch of errOut·grad[f]. After any other sample the model is unchanged.
- R5: In the 1-bit build, `inReady` is 0 in the cycle after a line is accepted.
- R6: Counting from the cycle in which `errValid` is 1, `inReady` stays 0 for GROUPS = NUM_FEAT/128 cycles, or for 2·GROUPS cycles when the sample closes a batch.
- R7: A line offered while `inReady` is 0 is ignored. Later errors and model values are those of a run without that line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Line offered |
| inReady | output | 1 | Line taken on this edge when inValid is also 1 |
| inLine | input | 512 | Packed feature pairs of one line |
| inLabel | input | 32 | Signed label, used on a sample's first line |
| errValid | output | 1 | One-cycle pulse: errOut holds a new scaled error |
| errOut | output | 32 | Scaled signed error of the latest sample |
| rdFeat | input | 9 | Feature index for model readout |
| rdData | output | 32 | Signed model word at rdFeat |

## Verification
Samples are driven with random copies, an all-ones dot copy (the error is then the model's total), an all-zero dot copy (the error depends on the label alone) and alternating bits. Together these separate errors in lane placement, half selection and sign handling. Batches are closed repeatedly, so a missed, early or doubled model update shows in the full readback that follows every sample. Junk lines held valid during a stall must leave every later error and model word unchanged, and the stall lengths are counted against the batch position.

// File: rtl/qsgd_pkg.sv
package qsgd_pkg;
  typedef enum logic [1:0] {PH_DOT, PH_WAIT, PH_GRAD, PH_UPD} phase_e;

  typedef struct packed {
    logic lineLoad;
    logic issue;
    logic passSel;
    logic lastPass;
    logic labelPush;
    logic gradEn;
    logic updEn;
  } strobe_t;
endpackage

// File: rtl/qsgd_fifo.sv
module qsgd_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == PW'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == PW'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= din;
  end

  assign dout = mem[rdPtr];
endmodule

// File: rtl/qsgd_ctrl.sv
module qsgd_ctrl
  import qsgd_pkg::*;
#(
  parameter int PASSES = 2,
  parameter int LINES  = 2,
  parameter int GROUPS = 4,
  parameter int BATCH  = 2,
  parameter int GRP_W  = 2,
  localparam int LC_W = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int BC_W = (BATCH > 1) ? $clog2(BATCH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic             dotDone,
  output strobe_t          stb,
  output logic [GRP_W-1:0] issueGrp,
  output logic [GRP_W-1:0] phaseGrp
);
  phase_e state;
  logic [LC_W-1:0] lineCnt;
  logic [BC_W-1:0] batchCnt;
  logic [GRP_W-1:0] issueCnt, phaseCnt;
  logic busyHalf, issueV, passSelR, accept, phaseLast;

  assign inReady   = (state == PH_DOT) && !busyHalf;
  assign accept    = inValid && inReady;
  assign phaseLast = (phaseCnt == GRP_W'(GROUPS-1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= PH_DOT;
      lineCnt  <= '0;
      batchCnt <= '0;
      issueCnt <= '0;
      phaseCnt <= '0;
      busyHalf <= 1'b0;
      issueV   <= 1'b0;
      passSelR <= 1'b0;
    end else begin
      issueV <= 1'b0;
      if (accept) begin
        issueV   <= 1'b1;
        passSelR <= 1'b0;
        busyHalf <= (PASSES == 2);
        if (lineCnt == LC_W'(LINES-1)) begin
          lineCnt <= '0;
          state   <= PH_WAIT;
        end else begin
          lineCnt <= lineCnt + 1'b1;
        end
      end else if (busyHalf) begin
        issueV   <= 1'b1;
        passSelR <= 1'b1;
        busyHalf <= 1'b0;
      end
      if (issueV) issueCnt <= (issueCnt == GRP_W'(GROUPS-1)) ? '0 : issueCnt + 1'b1;
      case (state)
        PH_WAIT: if (dotDone) begin
          state    <= PH_GRAD;
          phaseCnt <= '0;
        end
        PH_GRAD: if (phaseLast) begin
          phaseCnt <= '0;
          if (batchCnt == BC_W'(BATCH-1)) begin
            batchCnt <= '0;
            state    <= PH_UPD;
          end else begin
            batchCnt <= batchCnt + 1'b1;
            state    <= PH_DOT;
          end
        end else begin
          phaseCnt <= phaseCnt + 1'b1;
        end
        PH_UPD: if (phaseLast) begin
          phaseCnt <= '0;
          state    <= PH_DOT;
        end else begin
          phaseCnt <= phaseCnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign stb.lineLoad  = accept;
  assign stb.issue     = issueV;
  assign stb.passSel   = passSelR;
  assign stb.lastPass  = issueV && (issueCnt == GRP_W'(GROUPS-1));
  assign stb.labelPush = accept && (lineCnt == '0);
  assign stb.gradEn    = (state == PH_GRAD);
  assign stb.updEn     = (state == PH_UPD);
  assign issueGrp      = issueCnt;
  assign phaseGrp      = phaseCnt;
endmodule

// File: rtl/qsgd_datapath.sv
module qsgd_datapath
  import qsgd_pkg::*;
#(
  parameter int LINE_BITS  = 512,
  parameter int QBITS      = 1,
  parameter int PASSES     = 2,
  parameter int LANES      = 128,
  parameter int GROUPS     = 4,
  parameter int GRP_W      = 2,
  parameter int FEAT_W     = 9,
  parameter int STEP_SHIFT = 2,
  localparam int LANE_W = $clog2(LANES),
  localparam int LEVELS = $clog2(LANES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [GRP_W-1:0]     issueGrp,
  input  logic [GRP_W-1:0]     phaseGrp,
  input  logic [LINE_BITS-1:0] inLine,
  input  logic [31:0]          inLabel,
  output logic                 dotDone,
  output logic                 errValid,
  output logic [31:0]          errOut,
  input  logic [FEAT_W-1:0]    rdFeat,
  output logic [31:0]          rdData
);
  logic [LINE_BITS-1:0] lineReg;
  logic signed [31:0] modelMem [GROUPS][LANES];
  logic signed [31:0] gradMem  [GROUPS][LANES];
  logic signed [31:0] lvl0 [LANES];
  logic signed [31:0] termArr [LANES];
  logic signed [31:0] dotAcc, errReg, treeSum, diff;
  logic [LANES*QBITS-1:0] aIn, aOut;
  logic [31:0] bOut;
  logic [LEVELS:0] vPipe, lPipe;

  always_ff @(posedge clk) begin
    if (stb.lineLoad) lineReg <= inLine;
  end

  for (genvar l = 0; l < LANES; l++) begin : laneG
    logic [QBITS-1:0] dotF, gradF;
    logic signed [31:0] prod;
    if (PASSES == 2) begin : twoP
      assign dotF = stb.passSel ? lineReg[2*QBITS*(LANES+l) +: QBITS] : lineReg[2*QBITS*l +: QBITS];
      assign aIn[l*QBITS +: QBITS] = stb.passSel ? lineReg[2*QBITS*(LANES+l)+QBITS +: QBITS]
                                                 : lineReg[2*QBITS*l+QBITS +: QBITS];
    end else begin : oneP
      assign dotF = lineReg[2*QBITS*l +: QBITS];
      assign aIn[l*QBITS +: QBITS] = lineReg[2*QBITS*l+QBITS +: QBITS];
    end
    assign gradF = aOut[l*QBITS +: QBITS];
    if (QBITS == 1) begin : muxMul
      assign prod       = dotF[0]  ? modelMem[issueGrp][l] : 32'sd0;
      assign termArr[l] = gradF[0] ? errReg : 32'sd0;
    end else begin : intMul
      logic signed [31:0] dotV, gradV;
      assign dotV       = {{(32-QBITS){dotF[QBITS-1]}}, dotF};
      assign gradV      = {{(32-QBITS){gradF[QBITS-1]}}, gradF};
      assign prod       = modelMem[issueGrp][l] * dotV;
      assign termArr[l] = errReg * gradV;
    end
    always_ff @(posedge clk) lvl0[l] <= prod;
  end

  for (genvar lv = 1; lv <= LEVELS; lv++) begin : treeLvl
    logic signed [31:0] node [LANES >> lv];
    for (genvar k = 0; k < (LANES >> lv); k++) begin : addG
      if (lv == 1) begin : first
        always_ff @(posedge clk) node[k] <= lvl0[2*k] + lvl0[2*k+1];
      end else begin : upper
        always_ff @(posedge clk) node[k] <= treeLvl[lv-1].node[2*k] + treeLvl[lv-1].node[2*k+1];
      end
    end
  end
  assign treeSum = treeLvl[LEVELS].node[0];

  qsgd_fifo #(.WIDTH(LANES*QBITS), .DEPTH(GROUPS)) u_aFifo (
    .clk(clk), .rstN(rstN), .push(stb.issue), .din(aIn), .pop(stb.gradEn), .dout(aOut));
  qsgd_fifo #(.WIDTH(32), .DEPTH(2)) u_bFifo (
    .clk(clk), .rstN(rstN), .push(stb.labelPush), .din(inLabel), .pop(dotDone), .dout(bOut));

  assign dotDone = vPipe[LEVELS] && lPipe[LEVELS];
  assign diff    = dotAcc + treeSum - $signed(bOut);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vPipe    <= '0;
      lPipe    <= '0;
      dotAcc   <= '0;
      errReg   <= '0;
      errValid <= 1'b0;
    end else begin
      vPipe    <= {vPipe[LEVELS-1:0], stb.issue};
      lPipe    <= {lPipe[LEVELS-1:0], stb.lastPass};
      errValid <= dotDone;
      if (dotDone) begin
        errReg <= diff >>> STEP_SHIFT;
        dotAcc <= '0;
      end else if (vPipe[LEVELS]) begin
        dotAcc <= dotAcc + treeSum;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int g = 0; g < GROUPS; g++)
        for (int l = 0; l < LANES; l++) begin
          modelMem[g][l] <= '0;
          gradMem[g][l]  <= '0;
        end
    end else if (stb.gradEn) begin
      for (int l = 0; l < LANES; l++) gradMem[phaseGrp][l] <= gradMem[phaseGrp][l] + termArr[l];
    end else if (stb.updEn) begin
      for (int l = 0; l < LANES; l++) begin
        modelMem[phaseGrp][l] <= modelMem[phaseGrp][l] - gradMem[phaseGrp][l];
        gradMem[phaseGrp][l]  <= '0;
      end
    end
  end

  assign errOut = errReg;
  assign rdData = modelMem[rdFeat[FEAT_W-1:LANE_W]][rdFeat[LANE_W-1:0]];
endmodule

// File: rtl/qsgd_engine.sv
module qsgd_engine
  import qsgd_pkg::*;
#(
  parameter int LINE_BITS  = 512,
  parameter int QBITS      = 1,
  parameter int NUM_FEAT   = 512,
  parameter int BATCH      = 2,
  parameter int STEP_SHIFT = 2,
  localparam int FPL    = LINE_BITS / (2*QBITS),
  localparam int PASSES = (QBITS == 1) ? 2 : 1,
  localparam int LANES  = FPL / PASSES,
  localparam int LINES  = NUM_FEAT / FPL,
  localparam int GROUPS = NUM_FEAT / LANES,
  localparam int GRP_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int FEAT_W = $clog2(NUM_FEAT)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  output logic                 inReady,
  input  logic [LINE_BITS-1:0] inLine,
  input  logic [31:0]          inLabel,
  output logic                 errValid,
  output logic [31:0]          errOut,
  input  logic [FEAT_W-1:0]    rdFeat,
  output logic [31:0]          rdData
);
  strobe_t stb;
  logic [GRP_W-1:0] issueGrp, phaseGrp;
  logic dotDone;

  qsgd_ctrl #(.PASSES(PASSES), .LINES(LINES), .GROUPS(GROUPS), .BATCH(BATCH), .GRP_W(GRP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .dotDone(dotDone),
    .stb(stb), .issueGrp(issueGrp), .phaseGrp(phaseGrp));

  qsgd_datapath #(.LINE_BITS(LINE_BITS), .QBITS(QBITS), .PASSES(PASSES), .LANES(LANES),
                  .GROUPS(GROUPS), .GRP_W(GRP_W), .FEAT_W(FEAT_W), .STEP_SHIFT(STEP_SHIFT)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .issueGrp(issueGrp), .phaseGrp(phaseGrp),
    .inLine(inLine), .inLabel(inLabel), .dotDone(dotDone), .errValid(errValid), .errOut(errOut),
    .rdFeat(rdFeat), .rdData(rdData));
endmodule

// File: rtl/qsgd_engine_chk.sv
module qsgd_engine_chk #(
  parameter int QBITS  = 1,
  parameter int FEAT_W = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic              errValid,
  input logic [FEAT_W-1:0] rdFeat,
  input logic [31:0]       rdData
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |=> !errValid);

  // R3
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) errValid |=> !errValid);

  // R6
  stall_chk: assert property (@(posedge clk) disable iff (!rstN) errValid |-> !inReady);

  // R4
  model_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inReady && $past(inReady) && $stable(rdFeat)) |-> $stable(rdData));

  if (QBITS == 1) begin : halfG
    // R5
    half_rate_chk: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && inReady) |=> !inReady);
  end
endmodule

bind qsgd_engine qsgd_engine_chk #(.QBITS(QBITS), .FEAT_W(FEAT_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .errValid(errValid), .rdFeat(rdFeat), .rdData(rdData));

// File: tb/qsgd_engine_bench.sv
`timescale 1ns/1ps
module qsgd_engine_bench;
  localparam int NF = 512, FPL = 256, LINES = 2, G = 4, BATCH = 2, SH = 2;

  logic clk = 1'b0, rstN = 1'b0;
  always #4 clk = ~clk;

  logic inValid = 1'b0, inReady, errValid;
  logic [511:0] inLine = '0;
  logic [31:0] inLabel = '0, errOut, rdData;
  logic [8:0] rdFeat = '0;

  qsgd_engine u_qsgd_engine (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inLine(inLine),
    .inLabel(inLabel), .errValid(errValid), .errOut(errOut), .rdFeat(rdFeat), .rdData(rdData));

  int nVec = 0, nBad = 0, cyc = 0, batchCnt = 0;
  int refModel[NF];
  int refGrad[NF];
  bit qd[NF];
  bit qg[NF];
  bit errWindow = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkModel(input string req);
    int bad = 0;
    for (int f = 0; f < NF; f++) begin
      rdFeat = 9'(f);
      #1;
      if ($signed(rdData) !== refModel[f]) begin
        if (bad == 0) $display("FAIL %s feature %0d actual=%0d expected=%0d", req, f, $signed(rdData), refModel[f]);
        bad++;
      end
    end
    nVec++;
    if (bad != 0) nBad++;
  endtask

  task automatic sendLine(input int ln, input int label);
    logic [511:0] w;
    for (int j = 0; j < FPL; j++) begin
      w[2*j]   = qd[ln*FPL + j];   // R2 dot copy in the low bit
      w[2*j+1] = qg[ln*FPL + j];   // R2 gradient copy in the high bit
    end
    do @(negedge clk); while (!inReady);
    inValid = 1'b1;
    inLine  = w;
    inLabel = label;
    @(negedge clk);
    inValid = 1'b0;
    check("R5 ready after accept", int'(inReady), 0);
  endtask

  // pattern: 0 random, 1 dot all ones, 2 dot all zero, 3 alternating
  task automatic runSample(input int pattern, input int label, input bit junk, input string errTag);
    int dot = 0, expErr, n = 0, waitCnt = 0;
    bit closing;
    for (int f = 0; f < NF; f++) begin
      case (pattern)
        1: qd[f] = 1'b1;
        2: qd[f] = 1'b0;
        3: qd[f] = f[0];
        default: qd[f] = 1'($urandom_range(0, 1));
      endcase
      qg[f] = 1'($urandom_range(0, 1));
    end
    for (int f = 0; f < NF; f++) if (qd[f]) dot += refModel[f];
    expErr = (dot - label) >>> SH;
    errWindow = 1'b1;
    for (int ln = 0; ln < LINES; ln++) sendLine(ln, (ln == 0) ? label : label + 777);
    while (!errValid && waitCnt < 200) begin
      @(negedge clk);
      waitCnt++;
    end
    check("R3 errValid seen", int'(errValid), 1);
    check(errTag, $signed(errOut), expErr);
    if (junk) begin
      inValid = 1'b1;              // R7 junk offered while stalled
      inLine  = {16{32'hA5C3_F00F}};
      inLabel = 32'h1234_5678;
    end
    while (!inReady && n < 50) begin
      @(negedge clk);
      n++;
      if (n == G - 1) inValid = 1'b0;
    end
    inValid = 1'b0;
    errWindow = 1'b0;
    for (int f = 0; f < NF; f++) if (qg[f]) refGrad[f] += expErr;
    closing = (batchCnt == BATCH - 1);
    if (closing) begin
      for (int f = 0; f < NF; f++) begin
        refModel[f] -= refGrad[f];
        refGrad[f] = 0;
      end
      batchCnt = 0;
    end else begin
      batchCnt++;
    end
    check("R6 stall length", n, closing ? 2*G : G);
    checkModel(junk ? "R7 model after junk" : "R4 model");
  endtask

  always @(negedge clk) begin
    if (rstN && errValid && !errWindow) begin
      nVec++;
      nBad++;
      $display("FAIL R3 unexpected errValid actual=1 expected=0");
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nBad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    for (int f = 0; f < NF; f++) begin
      refModel[f] = 0;
      refGrad[f]  = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 inReady", int'(inReady), 1);
    check("R1 errValid", int'(errValid), 0);
    checkModel("R1 model zero");
    runSample(0, 1000, 1'b0, "R3 err random");
    runSample(1, -400, 1'b0, "R3 err all ones");
    runSample(1, 37, 1'b0, "R2 err all ones after update");
    runSample(2, 13, 1'b1, "R3 err all zero");
    runSample(0, 250, 1'b0, "R7 err after junk");
    runSample(3, -91, 1'b0, "R2 err alternating");
    runSample(0, 2000000, 1'b1, "R3 err large label");
    runSample(0, -5, 1'b0, "R7 err after junk at batch end");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule